// File: doc/BRIEF.md
# Multi-Zone Static Memory Bus Controller

This block sits between a 16-bit internal core bus and external static devices: SRAM, ROM, flash and memory-mapped I/O. Software loads one configuration word per zone through a simple write port. Each word gives the zone's base address, its power-of-two size and its access timing. Each core request is decoded against the four zones. The block then runs the matching external read or write cycle, with that zone's timing and data width, and reports completion with a one-clock done pulse.

Each zone has its own settings: wait states, hold clocks, and early or late write strobe timing. It can also use fast reads, or burst fetching of the second byte of a word from an 8-bit device. An 8-bit zone receives a core word access as two byte accesses, low byte first. A zone can also ask for one idle clock before it is entered from a different zone, which gives slow devices time to release the bus. An address that falls in no zone still completes, but it returns zero and flags an error.

Top module: `sbc_static_bus`

## Requirements
- R1: A write on the configuration port with `cfg_we` high loads `cfg_wdata` into the zone named by `cfg_sel`. The fields are: bits [15:0] base address; [19:16] size code s (0 disables the zone, otherwise the zone covers 2^s bytes, aligned on its base); [22:20] wait states; [24:23] hold clocks; [25] 8-bit width; [26] burst; [27] fast read; [28] late write; [30:29] burst stretch; [31] idle-on-entry. Reset clears every zone to disabled. If zones overlap, the lowest-numbered zone wins. At most one active-low select `mem_cs_n[z]` is low at any time.
- R2: A request is accepted on a clock edge where `core_req` and `core_ready` are both high. On a 16-bit zone with no waits, the access takes 2 bus clocks: an address clock, then a data clock in which `mem_rd_n` (for a read) is low. `core_done` rises in the clock after the last bus clock. `mem_be_n` is the inverse of the byte enables, and read lanes that are not enabled return zero. A byte-enable value of 00 is treated as 11.
- R3: Wait states W lengthen the data phase of every access in the zone to 1+W clocks, and the read strobe stays low through all of them.
- R4: Hold clocks H are added once at the end of a transaction. During them the select, address and write data stay driven and both strobes are high.
- R5: A fast-read zone drops the address clock of each read access, so each access takes 1+W clocks. Writes to the zone are not affected.
- R6: With early write, `mem_wr_n` is low only in the address clock of each access. With late write, it is low for every data-phase clock. `mem_doe` is high, and `mem_dout` holds the write data, for every clock in which the select is low.
- R7: In an 8-bit zone each enabled byte is a separate access, low byte first. The byte address is the core address with bit 0 replaced by the lane number, data travels on bits [7:0] of the external bus, and `mem_be_n` is 10.
- R8: In an 8-bit burstable zone, the second byte of a word read is a burst beat of 1+S clocks, where S is the burst stretch and a stretch of 3 acts as 2. The read strobe stays low from the first byte through the beat.
- R9: When a zone has idle-on-entry set and the previous successful transaction went to a different zone, one clock with every select high is inserted before the access.
- R10: An address that matches no enabled zone completes after 2 clocks with no select and no strobe. A read returns 0, and `core_err` is high together with `core_done`.
- R11: `core_done` and `core_err` are single-clock pulses, and `core_ready` is high only when no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Zone to configure |
| cfg_wdata | input | 32 | Zone configuration word |
| core_req | input | 1 | Transaction request |
| core_ready | output | 1 | Controller idle, request may be taken |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Byte address (bit 0 ignored) |
| core_be | input | 2 | Byte lane enables |
| core_wdata | input | 16 | Write data |
| core_done | output | 1 | Transaction complete pulse |
| core_err | output | 1 | No-zone error pulse |
| core_rdata | output | 16 | Read data |
| mem_cs_n | output | 4 | Active-low zone selects |
| mem_addr | output | 16 | External address |
| mem_be_n | output | 2 | Active-low external byte enables |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_doe | output | 1 | Write data output enable |
| mem_dout | output | 16 | Write data to devices |
| mem_din | input | 16 | Read data from devices |

## Verification
The hardest situations to reach combine several per-zone options in one transaction. Examples are a burst beat that follows a waited first byte, a fast split read that ends in hold, and an idle clock that appears only because of the zone used by the transaction before. The directed tasks set up four zones with deliberately different option mixes. They then order the transactions so that every zone change either asks for the idle clock or does not, including a change that follows an unmatched address. A second set of overlapping zone bases reaches the decode priority.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // Timing and width settings of one zone; bit order matches the upper
  // sixteen bits of the configuration word.
  typedef struct packed {
    logic       idle_sw;
    logic [1:0] stretch;
    logic       late_wr;
    logic       fast;
    logic       burst;
    logic       width8;
    logic [1:0] hold;
    logic [2:0] wait_st;
    logic [3:0] size;
  } zone_tim_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_ADDR,
    ST_DATA,
    ST_BEAT,
    ST_HOLD
  } seq_st_t;

endpackage

// File: rtl/sbc_rst_sync.sv
module sbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sbc_cfg_regs.sv
module sbc_cfg_regs
  import sbc_pkg::*;
#(
  parameter int NZ = 4,
  parameter int AW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1,
  localparam int CW = AW + 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ZW-1:0]          cfg_sel,
  input  logic [CW-1:0]          cfg_wdata,
  output logic [NZ-1:0][AW-1:0]  zone_base,
  output zone_tim_t [NZ-1:0]     zone_tim
);
  for (genvar z = 0; z < NZ; z++) begin : g_zone
    logic load;
    assign load = cfg_we && (cfg_sel == ZW'(z));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zone_base[z] <= '0;
        zone_tim[z]  <= '0;
      end else if (load) begin
        zone_base[z] <= cfg_wdata[AW-1:0];
        zone_tim[z]  <= zone_tim_t'(cfg_wdata[CW-1:AW]);
      end
    end
  end
endmodule

// File: rtl/sbc_zone_decode.sv
module sbc_zone_decode
  import sbc_pkg::*;
#(
  parameter int NZ = 4,
  parameter int AW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic [AW-1:0]          addr,
  input  logic [NZ-1:0][AW-1:0]  zone_base,
  input  zone_tim_t [NZ-1:0]     zone_tim,
  output logic                   hit,
  output logic [ZW-1:0]          hit_zone,
  output zone_tim_t              hit_tim
);
  logic [NZ-1:0] match;

  for (genvar z = 0; z < NZ; z++) begin : g_match
    logic [AW-1:0] mask;
    assign mask     = {AW{1'b1}} << zone_tim[z].size;
    assign match[z] = (zone_tim[z].size != 4'd0) &&
                      (((addr ^ zone_base[z]) & mask) == '0);
  end

  always_comb begin
    hit      = 1'b0;
    hit_zone = '0;
    hit_tim  = '0;
    for (int z = NZ - 1; z >= 0; z--) begin
      if (match[z]) begin
        hit      = 1'b1;
        hit_zone = ZW'(z);
        hit_tim  = zone_tim[z];
      end
    end
  end
endmodule

// File: rtl/sbc_cycle_seq.sv
module sbc_cycle_seq
  import sbc_pkg::*;
#(
  parameter int NZ = 4,
  parameter int AW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           we,
  input  logic [AW-1:1]  addr_hi,
  input  logic [1:0]     be,
  input  logic [15:0]    wdata,
  input  logic           hit,
  input  logic [ZW-1:0]  hit_zone,
  input  zone_tim_t      hit_tim,
  output logic           ready,
  output logic           done,
  output logic           err,
  output logic [15:0]    rdata,
  output logic [NZ-1:0]  mem_cs_n,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_be_n,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           mem_doe,
  output logic [15:0]    mem_dout,
  input  logic [15:0]    mem_din
);
  seq_st_t       st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [ZW-1:0] zone_q, zone_d, last_zone_q, last_zone_d;
  zone_tim_t     tim_q, tim_d;
  logic          miss_q, miss_d, we_q, we_d, lane_q, lane_d;
  logic          second_q, second_d, last_vld_q, last_vld_d;
  logic          done_q, done_d, err_q, err_d;
  logic [AW-1:1] addr_q, addr_d;
  logic [15:0]   wdata_q, wdata_d, rdata_q, rdata_d;
  logic [1:0]    be_q, be_d, be_eff;
  logic          go_tail, go_fin, cap;

  assign be_eff = (be == 2'b00) ? 2'b11 : be;

  // next-state process
  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    zone_d      = zone_q;
    tim_d       = tim_q;
    miss_d      = miss_q;
    we_d        = we_q;
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    be_d        = be_q;
    lane_d      = lane_q;
    second_d    = second_q;
    rdata_d     = rdata_q;
    last_zone_d = last_zone_q;
    last_vld_d  = last_vld_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    go_tail     = 1'b0;
    go_fin      = 1'b0;
    cap         = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          zone_d  = hit_zone;
          tim_d   = hit_tim;
          miss_d  = !hit;
          we_d    = we;
          addr_d  = addr_hi;
          wdata_d = wdata;
          be_d    = be_eff;
          if (!we) rdata_d = '0;
          if (hit && hit_tim.width8) begin
            lane_d   = !be_eff[0];
            second_d = &be_eff;
          end else begin
            lane_d   = 1'b0;
            second_d = 1'b0;
          end
          if (hit && hit_tim.idle_sw && last_vld_q && (last_zone_q != hit_zone)) begin
            st_d = ST_GAP;
          end else if (hit && !we && hit_tim.fast) begin
            st_d  = ST_DATA;
            cnt_d = hit_tim.wait_st;
          end else begin
            st_d = ST_ADDR;
          end
        end
      end
      ST_GAP: begin
        if (!we_q && tim_q.fast) begin
          st_d  = ST_DATA;
          cnt_d = tim_q.wait_st;
        end else begin
          st_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        st_d  = ST_DATA;
        cnt_d = miss_q ? 3'd0 : tim_q.wait_st;
      end
      ST_DATA: begin
        if (cnt_q != 3'd0) begin
          cnt_d = cnt_q - 3'd1;
        end else begin
          cap = !we_q && !miss_q;
          if (second_q) begin
            second_d = 1'b0;
            lane_d   = 1'b1;
            if (!we_q && tim_q.burst) begin
              st_d  = ST_BEAT;
              cnt_d = (tim_q.stretch == 2'd3) ? 3'd2 : {1'b0, tim_q.stretch};
            end else if (!we_q && tim_q.fast) begin
              st_d  = ST_DATA;
              cnt_d = tim_q.wait_st;
            end else begin
              st_d = ST_ADDR;
            end
          end else begin
            go_tail = 1'b1;
          end
        end
      end
      ST_BEAT: begin
        if (cnt_q != 3'd0) begin
          cnt_d = cnt_q - 3'd1;
        end else begin
          cap     = 1'b1;
          go_tail = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q != 3'd0) cnt_d = cnt_q - 3'd1;
        else               go_fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (cap) begin
      if (tim_q.width8) begin
        if (lane_q) rdata_d[15:8] = mem_din[7:0];
        else        rdata_d[7:0]  = mem_din[7:0];
      end else begin
        rdata_d = {be_q[1] ? mem_din[15:8] : 8'h00, be_q[0] ? mem_din[7:0] : 8'h00};
      end
    end

    if (go_tail) begin
      if (!miss_q && (tim_q.hold != 2'd0)) begin
        st_d  = ST_HOLD;
        cnt_d = {1'b0, tim_q.hold} - 3'd1;
      end else begin
        go_fin = 1'b1;
      end
    end

    if (go_fin) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      err_d  = miss_q;
      if (!miss_q) begin
        last_zone_d = zone_q;
        last_vld_d  = 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      zone_q      <= '0;
      tim_q       <= '0;
      miss_q      <= 1'b0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      lane_q      <= 1'b0;
      second_q    <= 1'b0;
      rdata_q     <= '0;
      last_zone_q <= '0;
      last_vld_q  <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      zone_q      <= zone_d;
      tim_q       <= tim_d;
      miss_q      <= miss_d;
      we_q        <= we_d;
      addr_q      <= addr_d;
      wdata_q     <= wdata_d;
      be_q        <= be_d;
      lane_q      <= lane_d;
      second_q    <= second_d;
      rdata_q     <= rdata_d;
      last_zone_q <= last_zone_d;
      last_vld_q  <= last_vld_d;
      done_q      <= done_d;
      err_q       <= err_d;
    end
  end

  // external bus drive
  logic sel_act;
  assign sel_act = !miss_q && (st_q inside {ST_ADDR, ST_DATA, ST_BEAT, ST_HOLD});

  for (genvar z = 0; z < NZ; z++) begin : g_cs
    assign mem_cs_n[z] = !(sel_act && (zone_q == ZW'(z)));
  end

  assign mem_addr = {addr_q, tim_q.width8 ? lane_q : 1'b0};
  assign mem_be_n = !sel_act ? 2'b11 : (tim_q.width8 ? 2'b10 : ~be_q);
  assign mem_rd_n = !(sel_act && !we_q && (st_q inside {ST_DATA, ST_BEAT}));
  assign mem_wr_n = !(sel_act && we_q &&
                      (tim_q.late_wr ? (st_q == ST_DATA) : (st_q == ST_ADDR)));
  assign mem_doe  = sel_act && we_q;
  assign mem_dout = tim_q.width8 ? {8'h00, lane_q ? wdata_q[15:8] : wdata_q[7:0]} : wdata_q;

  assign ready = (st_q == ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  assert_strobe_in_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> (mem_cs_n != {NZ{1'b1}}));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> ($stable(mem_addr) && $stable(mem_cs_n) && mem_rd_n && mem_wr_n));

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && (mem_cs_n == {NZ{1'b1}})));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != {NZ{1'b1}}) |-> !ready);
endmodule

// File: rtl/sbc_static_bus.sv
module sbc_static_bus
  import sbc_pkg::*;
#(
  parameter int NZ = 4,
  parameter int AW = 16,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1,
  localparam int CW = AW + 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [ZW-1:0]  cfg_sel,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           core_req,
  output logic           core_ready,
  input  logic           core_we,
  input  logic [AW-1:0]  core_addr,
  input  logic [1:0]     core_be,
  input  logic [15:0]    core_wdata,
  output logic           core_done,
  output logic           core_err,
  output logic [15:0]    core_rdata,
  output logic [NZ-1:0]  mem_cs_n,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_be_n,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           mem_doe,
  output logic [15:0]    mem_dout,
  input  logic [15:0]    mem_din
);
  logic                  rst_n_sync;
  logic [NZ-1:0][AW-1:0] zone_base;
  zone_tim_t [NZ-1:0]    zone_tim;
  logic                  hit;
  logic [ZW-1:0]         hit_zone;
  zone_tim_t             hit_tim;

  sbc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sbc_cfg_regs #(.NZ(NZ), .AW(AW)) u_cfg_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .zone_base (zone_base),
    .zone_tim  (zone_tim)
  );

  sbc_zone_decode #(.NZ(NZ), .AW(AW)) u_zone_decode (
    .addr      (core_addr),
    .zone_base (zone_base),
    .zone_tim  (zone_tim),
    .hit       (hit),
    .hit_zone  (hit_zone),
    .hit_tim   (hit_tim)
  );

  sbc_cycle_seq #(.NZ(NZ), .AW(AW)) u_cycle_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .req      (core_req),
    .we       (core_we),
    .addr_hi  (core_addr[AW-1:1]),
    .be       (core_be),
    .wdata    (core_wdata),
    .hit      (hit),
    .hit_zone (hit_zone),
    .hit_tim  (hit_tim),
    .ready    (core_ready),
    .done     (core_done),
    .err      (core_err),
    .rdata    (core_rdata),
    .mem_cs_n (mem_cs_n),
    .mem_addr (mem_addr),
    .mem_be_n (mem_be_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .mem_doe  (mem_doe),
    .mem_dout (mem_dout),
    .mem_din  (mem_din)
  );
endmodule

// File: tb/sbc_static_bus_bench.sv
module sbc_static_bus_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        core_req = 1'b0;
  logic        core_ready;
  logic        core_we = 1'b0;
  logic [15:0] core_addr = '0;
  logic [1:0]  core_be = '0;
  logic [15:0] core_wdata = '0;
  logic        core_done, core_err;
  logic [15:0] core_rdata;
  logic [3:0]  mem_cs_n;
  logic [15:0] mem_addr;
  logic [1:0]  mem_be_n;
  logic        mem_rd_n, mem_wr_n, mem_doe;
  logic [15:0] mem_dout;
  logic [15:0] mem_din;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    pat = {a[7:0] ^ 8'h3C, a[7:0] + 8'h51};
  endfunction

  assign mem_din = pat(mem_addr);

  sbc_static_bus u_sbc_static_bus (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .core_req(core_req), .core_ready(core_ready), .core_we(core_we), .core_addr(core_addr),
    .core_be(core_be), .core_wdata(core_wdata), .core_done(core_done), .core_err(core_err),
    .core_rdata(core_rdata), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_doe(mem_doe), .mem_dout(mem_dout),
    .mem_din(mem_din)
  );

  // per-transaction trace, one entry per bus clock
  logic [3:0]  tr_cs   [32];
  logic        tr_rd   [32];
  logic        tr_wr   [32];
  logic        tr_doe  [32];
  logic [15:0] tr_addr [32];
  logic [15:0] tr_dout [32];
  logic [1:0]  tr_be   [32];
  int          n_clk;
  logic [15:0] got_rdata;
  logic        got_err;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cs_cnt(input int z);
    int c = 0;
    for (int i = 0; i < n_clk; i++) if (!tr_cs[i][z]) c++;
    return c;
  endfunction

  function automatic int rd_cnt();
    int c = 0;
    for (int i = 0; i < n_clk; i++) if (!tr_rd[i]) c++;
    return c;
  endfunction

  function automatic int wr_cnt();
    int c = 0;
    for (int i = 0; i < n_clk; i++) if (!tr_wr[i]) c++;
    return c;
  endfunction

  function automatic int wr_first();
    for (int i = 0; i < n_clk; i++) if (!tr_wr[i]) return i;
    return -1;
  endfunction

  function automatic int doe_cnt();
    int c = 0;
    for (int i = 0; i < n_clk; i++) if (tr_doe[i]) c++;
    return c;
  endfunction

  task automatic cfg(input int z, input logic [15:0] base, input int sz, input int ws,
                     input int hd, input bit w8, input bit bu, input bit fa, input bit lw,
                     input int stc, input bit idl);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = 2'(z);
    cfg_wdata = {idl, 2'(stc), lw, fa, bu, w8, 2'(hd), 3'(ws), 4'(sz), base};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic xfer(input bit we, input logic [15:0] a, input logic [1:0] be,
                      input logic [15:0] wd);
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    core_req   = 1'b1;
    core_we    = we;
    core_addr  = a;
    core_be    = be;
    core_wdata = wd;
    @(negedge clk);
    core_req = 1'b0;
    n_clk    = 0;
    while (!core_done && n_clk < 32) begin
      tr_cs[n_clk]   = mem_cs_n;
      tr_rd[n_clk]   = mem_rd_n;
      tr_wr[n_clk]   = mem_wr_n;
      tr_doe[n_clk]  = mem_doe;
      tr_addr[n_clk] = mem_addr;
      tr_dout[n_clk] = mem_dout;
      tr_be[n_clk]   = mem_be_n;
      n_clk++;
      @(negedge clk);
    end
    got_rdata = core_rdata;
    got_err   = core_err;
    @(negedge clk);
    chk("R11 done pulse", int'(core_done), 0);
    chk("R11 err pulse", int'(core_err), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset selects", int'(mem_cs_n), 4'hF);
    chk("R1 reset strobes", int'({mem_rd_n, mem_wr_n}), 2'b11);
    chk("R11 reset done", int'(core_done), 0);
    chk("R11 reset ready", int'(core_ready), 1);
    xfer(1'b0, 16'h0010, 2'b11, 16'h0);
    chk("R1 disabled zone miss err", int'(got_err), 1);
    chk("R10 miss length", n_clk, 2);
  endtask

  task automatic t_basic_16();
    xfer(1'b0, 16'h0124, 2'b11, 16'h0);
    chk("R2 basic length", n_clk, 2);
    chk("R2 cs0 clocks", cs_cnt(0), 2);
    chk("R2 rd low only in data clock", int'({tr_rd[0], tr_rd[1]}), 2'b10);
    chk("R2 word read data", int'(got_rdata), int'(pat(16'h0124)));
    chk("R2 word be_n", int'(tr_be[0]), 2'b00);
    chk("R2 no err", int'(got_err), 0);
    xfer(1'b0, 16'h0124, 2'b10, 16'h0);
    chk("R2 high lane read", int'(got_rdata), int'({pat(16'h0124) & 16'hFF00}));
    chk("R2 high lane be_n", int'(tr_be[1]), 2'b01);
    xfer(1'b1, 16'h0202, 2'b01, 16'h55AA);
    chk("R2 low lane write be_n", int'(tr_be[0]), 2'b10);
    chk("R6 early write at addr clock", wr_first(), 0);
    chk("R6 early write length", wr_cnt(), 1);
    chk("R6 write data", int'(tr_dout[1]), 16'h55AA);
    chk("R6 doe with select", doe_cnt(), 2);
  endtask

  task automatic t_wait_hold_idle();
    xfer(1'b0, 16'h1010, 2'b11, 16'h0);
    chk("R9 idle clock length", n_clk, 8);
    chk("R9 gap clock no select", int'(tr_cs[0]), 4'hF);
    chk("R4 cs1 clocks incl hold", cs_cnt(1), 7);
    chk("R3 waited read strobe", rd_cnt(), 4);
    chk("R4 hold strobes high", int'({tr_rd[6], tr_rd[7]}), 2'b11);
    chk("R4 hold addr kept", int'(tr_addr[7]), 16'h1010);
    chk("R3 waited read data", int'(got_rdata), int'(pat(16'h1010)));
    xfer(1'b1, 16'h1020, 2'b11, 16'hC0DE);
    chk("R9 same zone no gap", n_clk, 7);
    chk("R6 late write first clock", wr_first(), 1);
    chk("R6 late write length", wr_cnt(), 4);
    chk("R4 doe through hold", doe_cnt(), 7);
    chk("R4 dout in hold", int'(tr_dout[6]), 16'hC0DE);
  endtask

  task automatic t_byte_burst();
    xfer(1'b0, 16'h2040, 2'b11, 16'h0);
    chk("R8 burst length", n_clk, 5);
    chk("R8 strobe held through beat", rd_cnt(), 4);
    chk("R7 first byte addr", int'(tr_addr[2]), 16'h2040);
    chk("R8 beat addr", int'(tr_addr[3]), 16'h2041);
    chk("R7 byte lane be_n", int'(tr_be[1]), 2'b10);
    chk("R8 burst data", int'(got_rdata),
        int'({pat(16'h2041)[7:0], pat(16'h2040)[7:0]}));
    xfer(1'b0, 16'h2040, 2'b10, 16'h0);
    chk("R7 single high byte length", n_clk, 3);
    chk("R7 high byte addr", int'(tr_addr[0]), 16'h2041);
    chk("R7 high byte data", int'(got_rdata), int'({pat(16'h2041)[7:0], 8'h00}));
    xfer(1'b1, 16'h2050, 2'b11, 16'h1234);
    chk("R7 split write length", n_clk, 6);
    chk("R7 split write strobes", wr_cnt(), 2);
    chk("R7 low byte first", int'(tr_dout[0]), 16'h0034);
    chk("R7 high byte second", int'(tr_dout[3]), 16'h0012);
    chk("R7 second byte addr", int'(tr_addr[3]), 16'h2051);
  endtask

  task automatic t_fast();
    xfer(1'b0, 16'h3008, 2'b11, 16'h0);
    chk("R5 fast split read length", n_clk, 7);
    chk("R5 fast read strobe", rd_cnt(), 6);
    chk("R5 rd low from first clock", int'(tr_rd[0]), 0);
    chk("R5 fast read data", int'(got_rdata),
        int'({pat(16'h3009)[7:0], pat(16'h3008)[7:0]}));
    xfer(1'b1, 16'h3010, 2'b01, 16'h00AB);
    chk("R5 write keeps address clock", n_clk, 5);
    chk("R6 early write in fast zone", wr_first(), 0);
    chk("R7 byte write data", int'(tr_dout[0]), 16'h00AB);
  endtask

  task automatic t_miss();
    xfer(1'b0, 16'h8000, 2'b11, 16'h0);
    chk("R10 miss length", n_clk, 2);
    chk("R10 miss no select", cs_cnt(0) + cs_cnt(1) + cs_cnt(2) + cs_cnt(3), 0);
    chk("R10 miss no strobe", rd_cnt(), 0);
    chk("R10 miss data zero", int'(got_rdata), 0);
    chk("R10 miss err", int'(got_err), 1);
    xfer(1'b0, 16'h0300, 2'b11, 16'h0);
    chk("R9 no gap when idle bit clear", n_clk, 2);
  endtask

  task automatic t_priority();
    cfg(3, 16'h0000, 13, 2, 1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    xfer(1'b0, 16'h0100, 2'b11, 16'h0);
    chk("R1 lower zone wins", cs_cnt(0), 2);
    chk("R1 overlapping zone unselected", cs_cnt(3), 0);
    xfer(1'b0, 16'h1100, 2'b11, 16'h0);
    chk("R1 zone1 over zone3", cs_cnt(1), 7);
    chk("R1 zone3 quiet", cs_cnt(3), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // zone setup: base, size code, wait, hold, 8-bit, burst, fast, late, stretch, idle
    cfg(0, 16'h0000, 12, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    cfg(1, 16'h1000, 12, 3, 2, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1);
    cfg(2, 16'h2000, 12, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b0);
    cfg(3, 16'h3000, 12, 2, 1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    t_basic_16();
    t_wait_hold_idle();
    t_byte_burst();
    t_fast();
    t_miss();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule